// File: doc/BRIEF.md
# Registered Bus Transceiver

This block joins two 16-bit buses, A and B. Each can carry data to the other either straight through or from an internal register. The width is split into two independent 8-bit halves. Each half has its own enable, direction, pair of capture clocks and pair of source selects. The two halves can be driven with identical controls so that they act as one 16-bit path.

Each half holds two registers. One captures its slice of the A bus on the rising edge of that half's A-side capture clock. The other captures its slice of the B bus on the rising edge of the B-side capture clock. Capture ignores every enable, direction and select input, so data can be latched while both buses are isolated. The drive side is given as a data vector plus an enable vector per bus, which leaves the tri-state pad to the surrounding chip. Each output is chosen by a select mux with a consensus term. The consensus term keeps the output steady when the live and stored values agree.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Control bit g (oe_ni, dir_i, sel_ab_i, sel_ba_i, ab_clk_i, ba_clk_i) acts only on data bits [8g+7:8g]. Half 0 is bits 7:0 and half 1 is bits 15:8.
- R2: A rising edge of ab_clk_i[g] loads the half-g slice of a_i into that half's A-to-B register. A rising edge of ba_clk_i[g] loads the half-g slice of b_i into the B-to-A register. Capture happens whatever the values of oe_ni, dir_i, sel_ab_i and sel_ba_i.
- R3: When oe_ni[g] is 1, both a_oe_o[g] and b_oe_o[g] are 0, and the half keeps its registers and can still capture.
- R4: When oe_ni[g] is 0, dir_i[g]=0 gives a_oe_o[g]=1 and b_oe_o[g]=0, and dir_i[g]=1 gives b_oe_o[g]=1 and a_oe_o[g]=0. The two enables are never 1 together.
- R5: With sel_ab_i[g]=0 the half-g slice of b_o equals the same slice of a_i, combinationally. With sel_ba_i[g]=0 the slice of a_o equals the slice of b_i.
- R6: With sel_ab_i[g]=1 the slice of b_o equals the A-to-B register. With sel_ba_i[g]=1 the slice of a_o equals the B-to-A register. Both data outputs carry their selection whether or not they are enabled.
- R7: When the live and stored values of a path are equal, toggling its select causes no change event on the data output.
- R8: rst_ni low clears all four registers to zero at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of all registers |
| ab_clk_i | input | 2 | Per-half capture clock for A-side data |
| ba_clk_i | input | 2 | Per-half capture clock for B-side data |
| oe_ni | input | 2 | Per-half active-low output enable |
| dir_i | input | 2 | Per-half direction: 0 drives A, 1 drives B |
| sel_ab_i | input | 2 | Per-half B output source: 0 live A, 1 stored |
| sel_ba_i | input | 2 | Per-half A output source: 0 live B, 1 stored |
| a_i | input | 16 | Value seen on the A bus |
| b_i | input | 16 | Value seen on the B bus |
| a_o | output | 16 | Data to drive onto the A bus |
| a_oe_o | output | 2 | Per-half drive enable for the A bus |
| b_o | output | 16 | Data to drive onto the B bus |
| b_oe_o | output | 2 | Per-half drive enable for the B bus |

## Verification
The assertions are sampled on each half's capture edges. At every such edge they check that the drive enables follow the enable and direction inputs and are never both set. They also check that a live selection matches the opposite bus and that a stored selection returns the value captured at the previous edge. Several behaviours only the directed scenarios can show: the absence of a change event while a select toggles between equal sources, the asynchronous clear without any edge, and that a capture in one half leaves the other half's registers alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_gf_mux.sv
module xcvr_gf_mux #(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] sel_v;
  assign sel_v = {W{sel_i}};
  // consensus term holds y when live == stored during a select change
  assign y_o = (sel_v & stored_i) | (~sel_v & live_i) | (stored_i & live_i);
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_ni,
  input  logic         ab_clk_i,
  input  logic         ba_clk_i,
  input  lane_ctrl_t   ctrl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] ab_q, ba_q;

  xcvr_cap_reg #(.W(W)) u_ab_reg (.clk_i(ab_clk_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(ab_q));
  xcvr_cap_reg #(.W(W)) u_ba_reg (.clk_i(ba_clk_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(ba_q));

  xcvr_gf_mux #(.W(W)) u_b_mux (.sel_i(ctrl_i.sel_ab), .live_i(a_i), .stored_i(ab_q), .y_o(b_o));
  xcvr_gf_mux #(.W(W)) u_a_mux (.sel_i(ctrl_i.sel_ba), .live_i(b_i), .stored_i(ba_q), .y_o(a_o));

  assign a_oe_o = ~ctrl_i.oe_n & ~ctrl_i.dir;
  assign b_oe_o = ~ctrl_i.oe_n &  ctrl_i.dir;
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             rst_ni,
  input  logic [LANES-1:0] ab_clk_i,
  input  logic [LANES-1:0] ba_clk_i,
  input  logic [LANES-1:0] oe_ni,
  input  logic [LANES-1:0] dir_i,
  input  logic [LANES-1:0] sel_ab_i,
  input  logic [LANES-1:0] sel_ba_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [DW-1:0]    a_o,
  output logic [LANES-1:0] a_oe_o,
  output logic [DW-1:0]    b_o,
  output logic [LANES-1:0] b_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_ctrl_t ctrl;
    assign ctrl = '{oe_n: oe_ni[g], dir: dir_i[g], sel_ab: sel_ab_i[g], sel_ba: sel_ba_i[g]};

    xcvr_lane #(.W(LANE_W)) u_lane (
      .rst_ni  (rst_ni),
      .ab_clk_i(ab_clk_i[g]),
      .ba_clk_i(ba_clk_i[g]),
      .ctrl_i  (ctrl),
      .a_i     (a_i[g*LANE_W +: LANE_W]),
      .b_i     (b_i[g*LANE_W +: LANE_W]),
      .a_o     (a_o[g*LANE_W +: LANE_W]),
      .a_oe_o  (a_oe_o[g]),
      .b_o     (b_o[g*LANE_W +: LANE_W]),
      .b_oe_o  (b_oe_o[g])
    );
  end
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input logic             rst_ni,
  input logic [LANES-1:0] ab_clk_i,
  input logic [LANES-1:0] ba_clk_i,
  input logic [LANES-1:0] oe_ni,
  input logic [LANES-1:0] dir_i,
  input logic [LANES-1:0] sel_ab_i,
  input logic [LANES-1:0] sel_ba_i,
  input logic [DW-1:0]    a_i,
  input logic [DW-1:0]    b_i,
  input logic [DW-1:0]    a_o,
  input logic [LANES-1:0] a_oe_o,
  input logic [DW-1:0]    b_o,
  input logic [LANES-1:0] b_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic seen_ab, seen_ba;

    always_ff @(posedge ab_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) seen_ab <= 1'b0;
      else         seen_ab <= 1'b1;
    end
    always_ff @(posedge ba_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) seen_ba <= 1'b0;
      else         seen_ba <= 1'b1;
    end

    AST_OE_EXCL: assert property (@(posedge ab_clk_i[g]) disable iff (!rst_ni)
      !(a_oe_o[g] && b_oe_o[g])); // R4
    AST_ISOLATE: assert property (@(posedge ab_clk_i[g]) disable iff (!rst_ni)
      oe_ni[g] |-> (!a_oe_o[g] && !b_oe_o[g])); // R3
    AST_DRIVE_A: assert property (@(posedge ba_clk_i[g]) disable iff (!rst_ni)
      (!oe_ni[g] && !dir_i[g]) |-> a_oe_o[g]); // R4
    AST_DRIVE_B: assert property (@(posedge ab_clk_i[g]) disable iff (!rst_ni)
      (!oe_ni[g] && dir_i[g]) |-> b_oe_o[g]); // R4
    AST_LIVE_AB: assert property (@(posedge ab_clk_i[g]) disable iff (!rst_ni)
      !sel_ab_i[g] |-> (b_o[g*LANE_W +: LANE_W] == a_i[g*LANE_W +: LANE_W])); // R5
    AST_LIVE_BA: assert property (@(posedge ba_clk_i[g]) disable iff (!rst_ni)
      !sel_ba_i[g] |-> (a_o[g*LANE_W +: LANE_W] == b_i[g*LANE_W +: LANE_W])); // R5
    AST_STORED_AB: assert property (@(posedge ab_clk_i[g]) disable iff (!rst_ni)
      (seen_ab && sel_ab_i[g]) |-> (b_o[g*LANE_W +: LANE_W] == $past(a_i[g*LANE_W +: LANE_W]))); // R2
    AST_STORED_BA: assert property (@(posedge ba_clk_i[g]) disable iff (!rst_ni)
      (seen_ba && sel_ba_i[g]) |-> (a_o[g*LANE_W +: LANE_W] == $past(b_i[g*LANE_W +: LANE_W]))); // R6
  end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .rst_ni(rst_ni), .ab_clk_i(ab_clk_i), .ba_clk_i(ba_clk_i), .oe_ni(oe_ni),
  .dir_i(dir_i), .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i), .a_i(a_i), .b_i(b_i),
  .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
);

// File: tb/reg_bus_xcvr_tb.sv
module reg_bus_xcvr_tb;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int DW    = LANES * LW;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic             rst_ni;
  logic [LANES-1:0] ab_clk, ba_clk, oe_n, dir, sel_ab, sel_ba;
  logic [DW-1:0]    a_in, b_in;
  logic [DW-1:0]    a_out, b_out;
  logic [LANES-1:0] a_oe, b_oe;

  logic [DW-1:0] ab_exp, ba_exp;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int a_evt = 0, b_evt = 0;

  reg_bus_xcvr #(.LANES(LANES), .LANE_W(LW)) u_dut (
    .rst_ni(rst_ni), .ab_clk_i(ab_clk), .ba_clk_i(ba_clk), .oe_ni(oe_n),
    .dir_i(dir), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .a_i(a_in), .b_i(b_in),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  always @(a_out) a_evt++;
  always @(b_out) b_evt++;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      summary();
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ab(logic [LANES-1:0] m);
    @(negedge clk) ab_clk = ab_clk | m;
    for (int g = 0; g < LANES; g++) if (m[g]) ab_exp[g*LW +: LW] = a_in[g*LW +: LW];
    @(negedge clk) ab_clk = ab_clk & ~m;
    #1;
  endtask

  task automatic pulse_ba(logic [LANES-1:0] m);
    @(negedge clk) ba_clk = ba_clk | m;
    for (int g = 0; g < LANES; g++) if (m[g]) ba_exp[g*LW +: LW] = b_in[g*LW +: LW];
    @(negedge clk) ba_clk = ba_clk & ~m;
    #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; ab_clk = '0; ba_clk = '0; oe_n = '1; dir = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
    ab_exp = '0; ba_exp = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    sel_ab = '1; sel_ba = '1; a_in = 16'hFFFF; b_in = 16'hFFFF;
    #1;
    check("R8 reset AB regs", b_out, 16'h0000);
    check("R8 reset BA regs", a_out, 16'h0000);
  endtask

  task automatic t_isolation();
    oe_n = '1; dir = '1; sel_ab = '1; sel_ba = '1;
    a_in = 16'hA55A; b_in = 16'h3CC3;
    pulse_ab(2'b11);
    pulse_ba(2'b11);
    check("R3 enables off", {14'd0, a_oe | b_oe}, 16'd0);
    a_in = 16'h0000; b_in = 16'h0000;
    oe_n = '0; dir = '1; #1;
    check("R3 AB kept", b_out, 16'hA55A);
    check("R4 drive B", {14'd0, b_oe, a_oe}, {14'd0, 2'b11, 2'b00});
    dir = '0; #1;
    check("R3 BA kept", a_out, 16'h3CC3);
  endtask

  task automatic t_live();
    oe_n = '0; dir = '1; sel_ab = '0;
    foreach (a_in[i]) ; // no-op keeps loop style uniform
    for (int k = 0; k < 4; k++) begin
      a_in = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h1234 : 16'h8001;
      #1;
      check("R5 live A to B", b_out, a_in);
    end
    dir = '0; sel_ba = '0;
    for (int k = 0; k < 4; k++) begin
      b_in = (k == 0) ? 16'hC0DE : (k == 1) ? 16'h0001 : (k == 2) ? 16'hFFFF : 16'h7E00;
      #1;
      check("R5 live B to A", a_out, b_in);
    end
  endtask

  task automatic t_stored();
    // capture with controls pointing elsewhere
    oe_n = '0; dir = '0; sel_ab = '0; sel_ba = '0;
    a_in = 16'h5AC3;
    pulse_ab(2'b11);
    oe_n = '1; dir = '1;
    b_in = 16'h0F1E;
    pulse_ba(2'b11);
    a_in = 16'hFFFF; b_in = 16'h0000;
    oe_n = '0; dir = '1; sel_ab = '1; #1;
    check("R2 capture ignores controls / R6 stored A to B", b_out, 16'h5AC3);
    dir = '0; sel_ba = '1; #1;
    check("R6 stored B to A", a_out, 16'h0F1E);
    check("R6 B data while disabled", b_out, 16'h5AC3);
  endtask

  task automatic t_halves();
    oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b11; sel_ba = 2'b11;
    a_in = 16'h1177; b_in = 16'h2288;
    pulse_ab(2'b01);
    pulse_ba(2'b10);
    check("R1 per-half enables", {12'd0, b_oe, a_oe}, {12'd0, 2'b10, 2'b01});
    check("R1 half0 AB only", b_out, ab_exp);
    check("R1 half1 BA only", a_out, ba_exp);
    check("R1 half1 AB untouched", {8'd0, b_out[15:8]}, 16'h005A);
    check("R1 half0 BA untouched", {8'd0, a_out[7:0]}, 16'h001E);
    sel_ab = 2'b01; #1;
    check("R1 mixed select", b_out, {a_in[15:8], ab_exp[7:0]});
  endtask

  task automatic t_oe_matrix();
    for (int k = 0; k < 4; k++) begin
      oe_n = {2{k[1]}}; dir = {2{k[0]}}; #1;
      check("R4 enable decode", {12'd0, a_oe, b_oe},
            {12'd0, (k == 0) ? 2'b11 : 2'b00, (k == 1) ? 2'b11 : 2'b00});
    end
  endtask

  task automatic t_glitch();
    int ea, eb;
    oe_n = '0; dir = '1; sel_ab = '0; sel_ba = '0;
    a_in = 16'h6699; b_in = 16'h9966;
    pulse_ab(2'b11);
    pulse_ba(2'b11);
    #1; ea = a_evt; eb = b_evt;
    sel_ab = 2'b11; #2; sel_ab = 2'b00; #2; sel_ab = 2'b01; #2;
    check("R7 B output steady", b_evt, eb);
    sel_ba = 2'b11; #2; sel_ba = 2'b10; #2;
    check("R7 A output steady", a_evt, ea);
  endtask

  task automatic t_async_clear();
    sel_ab = '1; sel_ba = '1; #1;
    rst_ni = 1'b0; #3; rst_ni = 1'b1; #1;
    ab_exp = '0; ba_exp = '0;
    check("R8 async clear AB", b_out, ab_exp);
    check("R8 async clear BA", a_out, ba_exp);
  endtask

  initial begin
    t_reset();
    t_isolation();
    t_live();
    t_stored();
    t_halves();
    t_oe_matrix();
    t_glitch();
    t_async_clear();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule